// File: doc/BRIEF.md
# Security context save sequencer

This block walks the saved state of a crypto engine in a fixed nested order and streams it out as 128-bit blocks, which a downstream encryptor and memory writer then consume. One start pulse begins the walk. For every block the sequencer drives a source code and an index onto a read port. One cycle later it captures the 128-bit word that comes back and offers it on a valid/ready output.

A progress counter counts the accepted blocks. A walk only begins when that counter is zero. When the walk finishes, the counter is compared against its start value plus the variant's block total. The parameter `EXTENDED` adds public-key accelerator state before the constant trailer block. An abort input ends the walk at the next block boundary. Each run, and each refused start, ends with a one-cycle done pulse that carries a status code.

Top module: `ctx_save_seq`

## Requirements
- R1: After reset `out_valid_o` and `done_o` are 0 and `prog_cnt_o` is 0.
- R2: Source codes on `rd_src_o` are: 0 random data, 1 sticky bits, 2 symmetric key table, 3 RSA keys, 4 accelerator sticky bits, 5 accelerator keys, 6 trailer. The base variant emits 132 blocks in this order: (0,0), (1,0), (1,1), then 64 code-2 blocks, then 64 code-3 blocks, then (6,0).
- R3: Code-2 blocks carry index slot*4+sub, with slots 0..15 ascending. Within a slot, sub runs 0 key word-quad 0, 1 key word-quad 1, 2 original IV, 3 updated IV.
- R4: Code-3 blocks carry index key*16+quad, with quads ascending. The key numbers run 0 and 1 for slot 0 (exponent, then modulus), then 2 and 3 for slot 1.
- R5: With `EXTENDED`=1 the walk inserts (4,0) and then 512 code-5 blocks with index slot*128+quad (4 slots) after the RSA region and before the trailer, 645 blocks in total.
- R6: Every non-trailer block's `out_data_o` equals the `rd_data_i` word returned for the source and index shown on the read port while that block is offered.
- R7: The trailer block is the constant 0x00010203_04050607_08090A0B_0C0D0E0F, with 0x0C0D0E0F in bits 31:0 and 0x00010203 in bits 127:96.
- R8: `prog_cnt_o` rises by exactly one for each accepted block. At the end of a walk, `done_o` pulses with status 0 if the counter equals its start value plus the total, and with status 2 otherwise.
- R9: A start seen while idle with a non-zero counter emits no block and pulses `done_o` with status 1 on the next cycle.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `out_data_o`, `rd_src_o` and `rd_idx_o` stay unchanged and valid stays high.
- R11: An abort during a walk lets the block in flight complete its handshake. The block then returns to idle and pulses `done_o` with status 3. No further block is offered.
- R12: A start pulse during a walk has no effect on the order or count of blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (sampled while idle) |
| abort_i | input | 1 | Stop at next block boundary |
| rd_src_o | output | 3 | Read port source code |
| rd_idx_o | output | IDX_W | Read port index within the source |
| rd_data_i | input | 128 | Word returned for the current source/index |
| out_valid_o | output | 1 | Output block valid |
| out_ready_i | input | 1 | Downstream accepts the block |
| out_data_o | output | 128 | Output block |
| prog_cnt_o | output | CNT_W | Progress counter |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 ok, 1 already triggered, 2 count mismatch, 3 abort |

## Verification
Abort and a stalled handshake can fall on the same cycle. The bench lowers ready and raises abort together while a block is being offered. It then checks that the held block keeps its data, that it is still delivered once ready returns, that exactly one block more than before appears, and that status 3 follows with the output idle. A second overlap is a start pulse that lands in the middle of a walk under irregular backpressure. That case is judged by comparing the complete block order and count against the arithmetic layout.

// File: rtl/ctx_save_pkg.sv
package ctx_save_pkg;
  typedef enum logic [2:0] {
    SRC_RAND   = 3'd0,
    SRC_STICKY = 3'd1,
    SRC_SYMKEY = 3'd2,
    SRC_RSA    = 3'd3,
    SRC_PSTK   = 3'd4,
    SRC_PKEY   = 3'd5,
    SRC_TRAIL  = 3'd6
  } src_e;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_ALREADY  = 2'd1,
    ST_MISMATCH = 2'd2,
    ST_ABORT    = 2'd3
  } status_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_SEND  = 2'd2
  } seq_state_e;

  localparam logic [127:0] TRAILER_BLK =
    {32'h00010203, 32'h04050607, 32'h08090A0B, 32'h0C0D0E0F};
endpackage

// File: rtl/ctx_region_walker.sv
module ctx_region_walker
  import ctx_save_pkg::*;
#(
  parameter bit EXTENDED = 1'b0,
  parameter int AES_LEN  = 64,
  parameter int RSA_LEN  = 64,
  parameter int PKA_LEN  = 512,
  parameter int IDX_W    = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output src_e             src_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  src_e             region_q, region_d, after_rsa;
  logic [IDX_W-1:0] idx_q, idx_max;

  generate
    if (EXTENDED) begin : g_ext
      assign after_rsa = SRC_PSTK;
    end else begin : g_base
      assign after_rsa = SRC_TRAIL;
    end
  endgenerate

  always_comb begin
    idx_max  = '0;
    region_d = region_q;
    unique case (region_q)
      SRC_RAND:   region_d = SRC_STICKY;
      SRC_STICKY: begin idx_max = IDX_W'(1);         region_d = SRC_SYMKEY; end
      SRC_SYMKEY: begin idx_max = IDX_W'(AES_LEN-1); region_d = SRC_RSA;    end
      SRC_RSA:    begin idx_max = IDX_W'(RSA_LEN-1); region_d = after_rsa;  end
      SRC_PSTK:   region_d = SRC_PKEY;
      SRC_PKEY:   begin idx_max = IDX_W'(PKA_LEN-1); region_d = SRC_TRAIL;  end
      default:    region_d = SRC_TRAIL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      region_q <= SRC_RAND;
      idx_q    <= '0;
    end else if (clr_i) begin
      region_q <= SRC_RAND;
      idx_q    <= '0;
    end else if (adv_i) begin
      if (idx_q == idx_max) begin
        region_q <= region_d;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign src_o  = region_q;
  assign idx_o  = idx_q;
  assign last_o = (region_q == SRC_TRAIL);

  assert_trailer_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_q == SRC_TRAIL) |-> (idx_q == '0));
  assert_no_accel_in_base_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !EXTENDED |-> (region_q != SRC_PSTK && region_q != SRC_PKEY));
endmodule

// File: rtl/ctx_prog_cnt.sv
module ctx_prog_cnt #(
  parameter int CNT_W = 16,
  parameter int TOTAL = 132
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             snap_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             end_ok_o
);
  logic [CNT_W-1:0] cnt_q, base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      if (inc_i)  cnt_q  <= cnt_q + 1'b1;
      if (snap_i) base_q <= cnt_q;
    end
  end

  assign cnt_o    = cnt_q;
  assign zero_o   = (cnt_q == '0);
  // compares the value the counter takes after the final block
  assign end_ok_o = ((cnt_q + 1'b1) == (base_q + CNT_W'(TOTAL)));

  assert_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_still_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/ctx_save_seq.sv
module ctx_save_seq
  import ctx_save_pkg::*;
#(
  parameter bit EXTENDED  = 1'b0,
  parameter int AES_SLOTS = 16,
  parameter int RSA_SLOTS = 2,
  parameter int RSA_QUADS = 16,
  parameter int PKA_SLOTS = 4,
  parameter int PKA_QUADS = 128,
  parameter int CNT_W     = 16,
  localparam int AES_LEN  = AES_SLOTS * 4,
  localparam int RSA_LEN  = RSA_SLOTS * 2 * RSA_QUADS,
  localparam int PKA_LEN  = PKA_SLOTS * PKA_QUADS,
  localparam int MAX_A    = (AES_LEN > RSA_LEN) ? AES_LEN : RSA_LEN,
  localparam int MAX_LEN  = (MAX_A > PKA_LEN) ? MAX_A : PKA_LEN,
  localparam int IDX_W    = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  output logic [2:0]        rd_src_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [127:0]      rd_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [127:0]      out_data_o,
  output logic [CNT_W-1:0]  prog_cnt_o,
  output logic              done_o,
  output logic [1:0]        status_o
);
  localparam int TOTAL = 1 + 2 + AES_LEN + RSA_LEN + (EXTENDED ? 1 + PKA_LEN : 0) + 1;

  seq_state_e       state_q;
  src_e             src;
  logic [IDX_W-1:0] idx;
  logic             last, cnt_zero, end_ok;
  logic             launch, accept, abort_pend_q, done_q;
  logic [127:0]     data_q;
  status_e          status_q;

  assign launch = (state_q == S_IDLE) && start_i && cnt_zero;
  assign accept = (state_q == S_SEND) && out_ready_i;

  ctx_region_walker #(
    .EXTENDED(EXTENDED), .AES_LEN(AES_LEN), .RSA_LEN(RSA_LEN),
    .PKA_LEN(PKA_LEN), .IDX_W(IDX_W)
  ) u_walker (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (launch),
    .adv_i (accept),
    .src_o (src),
    .idx_o (idx),
    .last_o(last)
  );

  ctx_prog_cnt #(.CNT_W(CNT_W), .TOTAL(TOTAL)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (accept),
    .snap_i  (launch),
    .cnt_o   (prog_cnt_o),
    .zero_o  (cnt_zero),
    .end_ok_o(end_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      data_q       <= '0;
      abort_pend_q <= 1'b0;
      done_q       <= 1'b0;
      status_q     <= ST_OK;
    end else begin
      done_q <= 1'b0;
      if (state_q != S_IDLE && abort_i) abort_pend_q <= 1'b1;
      unique case (state_q)
        S_IDLE: begin
          abort_pend_q <= 1'b0;
          if (start_i && !cnt_zero) begin
            done_q   <= 1'b1;
            status_q <= ST_ALREADY;
          end else if (launch) begin
            state_q <= S_FETCH;
          end
        end
        S_FETCH: begin
          data_q  <= last ? TRAILER_BLK : rd_data_i;
          state_q <= S_SEND;
        end
        S_SEND: begin
          if (out_ready_i) begin
            if (abort_pend_q || abort_i) begin
              state_q  <= S_IDLE;
              done_q   <= 1'b1;
              status_q <= ST_ABORT;
            end else if (last) begin
              state_q  <= S_IDLE;
              done_q   <= 1'b1;
              status_q <= end_ok ? ST_OK : ST_MISMATCH;
            end else begin
              state_q <= S_FETCH;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_src_o    = src;
  assign rd_idx_o    = idx;
  assign out_valid_o = (state_q == S_SEND);
  assign out_data_o  = data_q;
  assign done_o      = done_q;
  assign status_o    = status_q;

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(rd_src_o) && $stable(rd_idx_o)));
  assert_refuse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && start_i && prog_cnt_o != '0) |=>
      (done_o && status_o == ST_ALREADY && !out_valid_o));
  assert_total_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == ST_OK) |-> (prog_cnt_o == CNT_W'(TOTAL)));
  assert_abort_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == ST_ABORT) |-> !out_valid_o);
endmodule

// File: tb/ctx_save_seq_tb.sv
module ctx_save_seq_tb;
  localparam int IW = 9;
  localparam logic [127:0] TRAIL = 128'h00010203_04050607_08090A0B_0C0D0E0F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic b_start = 1'b0, e_start = 1'b0, abort = 1'b0, ready = 1'b0;
  logic [2:0]   b_src, e_src;
  logic [IW-1:0] b_idx, e_idx;
  logic [127:0] b_rd, e_rd, b_data, e_data;
  logic b_valid, e_valid, b_done, e_done;
  logic [15:0] b_cnt, e_cnt;
  logic [1:0]  b_st, e_st;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [127:0] model(input logic [2:0] s, input logic [IW-1:0] i);
    return {4'hA, 25'd0, s, 23'd0, i, 32'(s) * 32'd1000 + 32'(i), 32'hFEED0000 ^ 32'(i)};
  endfunction

  assign b_rd = model(b_src, b_idx);
  assign e_rd = model(e_src, e_idx);

  ctx_save_seq #(.EXTENDED(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(b_start), .abort_i(abort),
    .rd_src_o(b_src), .rd_idx_o(b_idx), .rd_data_i(b_rd),
    .out_valid_o(b_valid), .out_ready_i(ready), .out_data_o(b_data),
    .prog_cnt_o(b_cnt), .done_o(b_done), .status_o(b_st));

  ctx_save_seq #(.EXTENDED(1'b1)) u_ext (
    .clk_i(clk), .rst_ni(rst_n), .start_i(e_start), .abort_i(abort),
    .rd_src_o(e_src), .rd_idx_o(e_idx), .rd_data_i(e_rd),
    .out_valid_o(e_valid), .out_ready_i(ready), .out_data_o(e_data),
    .prog_cnt_o(e_cnt), .done_o(e_done), .status_o(e_st));

  logic sel = 1'b0;
  logic m_valid, m_done;
  logic [2:0] m_src;
  logic [IW-1:0] m_idx;
  logic [127:0] m_data;
  logic [1:0] m_st;
  always_comb begin
    m_valid = sel ? e_valid : b_valid;
    m_done  = sel ? e_done  : b_done;
    m_src   = sel ? e_src   : b_src;
    m_idx   = sel ? e_idx   : b_idx;
    m_data  = sel ? e_data  : b_data;
    m_st    = sel ? e_st    : b_st;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // arithmetic layout: block number -> source code and index
  task automatic expect_blk(input int n, input bit ext, output int s, output int i);
    if (n == 0)           begin s = 0; i = 0;      end
    else if (n < 3)       begin s = 1; i = n - 1;  end
    else if (n < 67)      begin s = 2; i = n - 3;  end
    else if (n < 131)     begin s = 3; i = n - 67; end
    else if (!ext)        begin s = 6; i = 0;      end
    else if (n == 131)    begin s = 4; i = 0;      end
    else if (n < 644)     begin s = 5; i = n - 132; end
    else                  begin s = 6; i = 0;      end
  endtask

  // mode 0: ready always; mode 1: irregular ready plus a mid-walk start; mode 2: abort
  task automatic run_walk(input bit ext, input int n_exp, input int mode, input int abort_at,
                          output int got, output int st, output bit saw_done);
    bit prev_hold = 1'b0, aborted = 1'b0;
    logic [127:0] pd = '0;
    logic [2:0] ps = '0;
    logic [IW-1:0] pi = '0;
    int s, i;
    logic [127:0] ed;
    got = 0; st = -1; saw_done = 1'b0;
    sel = ext;
    for (int cyc = 0; cyc < 5000; cyc++) begin
      @(negedge clk);
      b_start = 1'b0; e_start = 1'b0; abort = 1'b0;
      if (cyc == 0) begin
        if (ext) e_start = 1'b1; else b_start = 1'b1;
      end
      if (mode == 1 && cyc == 40) b_start = 1'b1; // R12 start while busy
      if (m_done) begin
        st = int'(m_st); saw_done = 1'b1;
        break;
      end
      if (prev_hold) begin
        check(m_valid && m_data == pd && m_src == ps && m_idx == pi, "R10",
              "stall hold", longint'(m_idx), longint'(pi));
      end
      ready = (mode == 1) ? ((cyc % 3) != 1) : 1'b1;
      if (mode == 2 && !aborted && got == abort_at && m_valid) begin
        ready = 1'b0; abort = 1'b1; aborted = 1'b1;  // R11 abort during stall
      end
      if (m_valid && ready) begin
        if (got < n_exp) begin
          expect_blk(got, ext, s, i);
          ed = (s == 6) ? TRAIL : model(3'(s), IW'(i));
          check(int'(m_src) == s, ext ? "R5" : "R2", "source", m_src, s);
          check(int'(m_idx) == i, (s == 2) ? "R3" : (s == 3) ? "R4" : "R2", "index", m_idx, i);
          check(m_data == ed, (s == 6) ? "R7" : "R6", "data", m_data[31:0], ed[31:0]);
        end else begin
          check(1'b0, "R2", "excess block", got, n_exp);
        end
        got++;
      end
      prev_hold = m_valid && !ready;
      pd = m_data; ps = m_src; pi = m_idx;
    end
    ready = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int got, st;
    bit sd;
    do_reset();
    check(!b_valid && !e_valid, "R1", "valid after reset", b_valid, 0);
    check(!b_done && !e_done, "R1", "done after reset", b_done, 0);
    check(b_cnt == 0 && e_cnt == 0, "R1", "counter after reset", b_cnt, 0);

    run_walk(1'b0, 132, 1, 0, got, st, sd);
    check(got == 132, "R2", "base block count (R12 start mid-walk)", got, 132);
    check(sd && st == 0, "R8", "base done status", st, 0);
    check(b_cnt == 132, "R8", "base counter", b_cnt, 132);

    @(negedge clk); b_start = 1'b1;
    @(negedge clk); b_start = 1'b0;
    check(b_done && b_st == 2'd1, "R9", "refused start status", b_st, 1);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(!b_valid, "R9", "no block after refusal", b_valid, 0);
    end
    check(b_cnt == 132, "R9", "counter unchanged", b_cnt, 132);

    run_walk(1'b1, 645, 0, 0, got, st, sd);
    check(got == 645, "R5", "extended block count", got, 645);
    check(sd && st == 0, "R8", "extended done status", st, 0);
    check(e_cnt == 645, "R8", "extended counter", e_cnt, 645);

    do_reset();
    run_walk(1'b1, 645, 2, 70, got, st, sd);
    check(got == 71, "R11", "blocks before abort stop", got, 71);
    check(sd && st == 3, "R11", "abort status", st, 3);
    check(e_cnt == 71, "R11", "counter at abort", e_cnt, 71);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(!e_valid, "R11", "idle after abort", e_valid, 0);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule